// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block carries out the memory side of a processor's exception handling. A pulse on `startEntry` makes it save the incoming status word and turn on supervisor mode with tracing off. It then reads the handler address from a vector table and pushes the interrupted PC and the saved status word onto the supervisor stack. When it finishes it presents the handler address as the new PC. A pulse on `startReturn` reverses the stack frame: it pops the status word, then the PC, and presents both together with the raised stack pointer.

Every memory cycle goes through one synchronous port. A request stays up, with its address and size unchanged, until the memory answers with ready or with a bus error. A bus error at any point in a sequence counts as a double fault and parks the block in a halted state. Only a qualified external reset clears that state. The reset request and halt request pins must both be low for ten clocks in a row before the block treats them as a reset. A qualified reset overrides anything in progress.

Top module: `trap_seq`

## Requirements
- R1: On an entry command, the status word given on `curSr` in that cycle is captured before any change. That unmodified value is the 16-bit word pushed on the stack, carried on `memWdata[15:0]`.
- R2: After an entry, `newSr` equals the captured status with bit 13 (supervisor) set to 1 and bit 15 (trace) cleared to 0. All other bits are unchanged.
- R3: The first access of an entry is a 32-bit read (`memSize`=1, `memWe`=0) at byte address 4 × `vecNum`.
- R4: The second access of an entry writes `curPc` as a 32-bit word at `sspIn`−4. The third access writes the captured status as a 16-bit word (`memSize`=0) at `sspIn`−6. `newSsp` ends at `sspIn`−6.
- R5: When the last push completes, `newPc` holds the word read from the vector table. `done` is high for exactly one cycle, in the cycle after that completion, and `busy` is low in that same cycle.
- R6: A return command reads a 16-bit word at `sspIn` into `newSr`, then a 32-bit word at `sspIn`+2 into `newPc`. `newSsp` ends at `sspIn`+6. A 16-bit read takes its value from `memRdata[15:0]`.
- R7: An access stays requested, with address, size and direction held, until `memReady` or `memBusErr`. With L wait cycles per access, an entry takes 3(L+1) cycles and a return takes 2(L+1) cycles from the command edge to `done`.
- R8: A bus error on any access stops the sequence and sets `halted`. While halted, no request is issued and commands are ignored, until a qualified reset.
- R9: A reset is recognised only at the 10th consecutive clock edge that samples both `extRstN` and `extHaltN` low. `resetTaken` rises at that edge. A shorter hold, or a break in the hold, restarts the count. Holding only one of the two pins low never qualifies.
- R10: A qualified reset aborts any sequence in progress and clears `halted`, leaving the block idle.
- R11: Commands that arrive while `busy` is high are ignored. If both commands arrive together in idle, the entry runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low register reset of the block |
| extRstN | input | 1 | Active-low external reset request |
| extHaltN | input | 1 | Active-low external halt request |
| startEntry | input | 1 | Begin exception entry (idle only) |
| startReturn | input | 1 | Begin return from exception (idle only) |
| vecNum | input | 8 | Vector number for an entry |
| curPc | input | 32 | PC of the interrupted program |
| curSr | input | 16 | Status word of the interrupted program |
| sspIn | input | 32 | Supervisor stack pointer at command time |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memSize | output | 1 | 1 = 32-bit, 0 = 16-bit |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data (16-bit writes on bits 15:0) |
| memRdata | input | 32 | Read data (16-bit reads on bits 15:0) |
| memReady | input | 1 | Access completes at this edge |
| memBusErr | input | 1 | Access fails at this edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Double fault halt |
| resetTaken | output | 1 | Qualified reset seen |
| newPc | output | 32 | Resulting PC |
| newSr | output | 16 | Resulting status word |
| newSsp | output | 32 | Resulting supervisor stack pointer |

## Verification
The in-RTL assertions check the following on every cycle:
- a pending access stays frozen until the memory answers;
- `done` is a single-cycle pulse;
- a bus error leads to a sticky halt with no further requests;
- a qualified reset always lands in an idle, unhalted state;
- an entry immediately sets the supervisor bit and clears the trace bit.

Only the directed scenarios show the rest:
- the actual frame contents and addresses, and the vector table address;
- the exact latency under wait states;
- the nine-versus-ten clock boundary of reset qualification;
- that commands sent mid-sequence, or while halted, leave the results untouched.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_VEC,
    ACC_PUSH_PC,
    ACC_PUSH_SR,
    ACC_POP_SR,
    ACC_POP_PC
  } acc_e;

  typedef struct packed {
    logic ldEntry;   // capture operands for an entry
    logic ldReturn;  // capture stack pointer for a return
    logic accDone;   // current access completes at this edge
    acc_e acc;       // which access is on the port
  } strobe_t;
endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int RST_HOLD = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    extRstN,
  input  logic    extHaltN,
  input  logic    startEntry,
  input  logic    startReturn,
  input  logic    memReady,
  input  logic    memBusErr,
  output strobe_t stb,
  output logic    memReq,
  output logic    busy,
  output logic    done,
  output logic    halted,
  output logic    resetTaken,
  output logic    rstHit
);
  localparam int CW = $clog2(RST_HOLD + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_VEC, ST_PPC, ST_PSR, ST_RSR, ST_RPC, ST_HALT} st_e;
  st_e st, stNxt;

  logic [CW-1:0] holdCnt;
  logic bothLow, accept;

  assign bothLow = !extRstN && !extHaltN;
  assign rstHit  = bothLow && (holdCnt == CW'(RST_HOLD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (!bothLow) holdCnt <= '0;
    else if (!rstHit) holdCnt <= holdCnt + 1'b1;
  end

  assign memReq = (st != ST_IDLE) && (st != ST_HALT);
  assign busy   = memReq;
  assign halted = (st == ST_HALT);
  assign accept = memReq && memReady && !memBusErr;

  always_comb begin
    stNxt = st;
    unique case (st)
      ST_IDLE: if (startEntry) stNxt = ST_VEC;
               else if (startReturn) stNxt = ST_RSR;
      ST_VEC:  if (accept) stNxt = ST_PPC;
      ST_PPC:  if (accept) stNxt = ST_PSR;
      ST_PSR:  if (accept) stNxt = ST_IDLE;
      ST_RSR:  if (accept) stNxt = ST_RPC;
      ST_RPC:  if (accept) stNxt = ST_IDLE;
      default: stNxt = st;
    endcase
    if (memReq && memBusErr) stNxt = ST_HALT;
    if (rstHit) stNxt = ST_IDLE;
  end

  always_comb begin
    stb = '0;
    stb.acc = ACC_NONE;
    unique case (st)
      ST_VEC:  stb.acc = ACC_VEC;
      ST_PPC:  stb.acc = ACC_PUSH_PC;
      ST_PSR:  stb.acc = ACC_PUSH_SR;
      ST_RSR:  stb.acc = ACC_POP_SR;
      ST_RPC:  stb.acc = ACC_POP_PC;
      default: stb.acc = ACC_NONE;
    endcase
    stb.accDone  = accept && !rstHit;
    stb.ldEntry  = (st == ST_IDLE) && startEntry && !rstHit;
    stb.ldReturn = (st == ST_IDLE) && !startEntry && startReturn && !rstHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      done       <= 1'b0;
      resetTaken <= 1'b0;
    end else begin
      st         <= stNxt;
      done       <= accept && !rstHit && ((st == ST_PSR) || (st == ST_RPC));
      resetTaken <= rstHit;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R5
  AST_HALT_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memBusErr && !rstHit) |=> halted);  // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !rstHit) |=> (halted && !memReq));  // R8
  AST_RST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rstHit |=> (!busy && !halted && resetTaken));  // R10
endmodule

// File: rtl/trap_seq_dpath.sv
module trap_seq_dpath
  import trap_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SRW   = 16,
  parameter int VW    = 8,
  parameter int S_BIT = 13,
  parameter int T_BIT = 15
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic [VW-1:0]  vecNum,
  input  logic [AW-1:0]  curPc,
  input  logic [SRW-1:0] curSr,
  input  logic [AW-1:0]  sspIn,
  input  logic [AW-1:0]  memRdata,
  output logic           memWe,
  output logic           memSize,
  output logic [AW-1:0]  memAddr,
  output logic [AW-1:0]  memWdata,
  output logic [AW-1:0]  newPc,
  output logic [AW-1:0]  newSr,
  output logic [AW-1:0]  newSsp
);
  localparam int PC_BYTES = AW / 8;
  localparam int SR_BYTES = SRW / 8;

  logic [AW-1:0]  pcReg, sspReg, handler;
  logic [SRW-1:0] srReg, tmpSr, srEntry;
  logic [VW-1:0]  vecReg;

  always_comb begin
    srEntry        = curSr;
    srEntry[S_BIT] = 1'b1;
    srEntry[T_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg   <= '0;
      sspReg  <= '0;
      handler <= '0;
      srReg   <= '0;
      tmpSr   <= '0;
      vecReg  <= '0;
    end else begin
      if (stb.ldEntry) begin
        tmpSr  <= curSr;
        srReg  <= srEntry;
        pcReg  <= curPc;
        sspReg <= sspIn;
        vecReg <= vecNum;
      end
      if (stb.ldReturn) sspReg <= sspIn;
      if (stb.accDone) begin
        unique case (stb.acc)
          ACC_VEC:     handler <= memRdata;
          ACC_PUSH_PC: sspReg  <= sspReg - AW'(PC_BYTES);
          ACC_PUSH_SR: begin
            sspReg <= sspReg - AW'(SR_BYTES);
            pcReg  <= handler;
          end
          ACC_POP_SR: begin
            srReg  <= memRdata[SRW-1:0];
            sspReg <= sspReg + AW'(SR_BYTES);
          end
          ACC_POP_PC: begin
            pcReg  <= memRdata;
            sspReg <= sspReg + AW'(PC_BYTES);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    memWe    = 1'b0;
    memSize  = 1'b1;
    memAddr  = sspReg;
    memWdata = '0;
    unique case (stb.acc)
      ACC_VEC:     memAddr = AW'({vecReg, 2'b00});
      ACC_PUSH_PC: begin
        memWe    = 1'b1;
        memAddr  = sspReg - AW'(PC_BYTES);
        memWdata = pcReg;
      end
      ACC_PUSH_SR: begin
        memWe    = 1'b1;
        memSize  = 1'b0;
        memAddr  = sspReg - AW'(SR_BYTES);
        memWdata = AW'(tmpSr);
      end
      ACC_POP_SR:  memSize = 1'b0;
      default: ;
    endcase
  end

  assign newPc  = pcReg;
  assign newSr  = AW'(srReg);
  assign newSsp = sspReg;

  AST_SUPERVISOR_ON: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldEntry |=> (srReg[S_BIT] && !srReg[T_BIT]));  // R2
  AST_SAVED_SR_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.acc == ACC_PUSH_SR) |-> $stable(tmpSr));  // R1
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SRW      = 16,
  parameter int VW       = 8,
  parameter int S_BIT    = 13,
  parameter int T_BIT    = 15,
  parameter int RST_HOLD = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           extRstN,
  input  logic           extHaltN,
  input  logic           startEntry,
  input  logic           startReturn,
  input  logic [VW-1:0]  vecNum,
  input  logic [AW-1:0]  curPc,
  input  logic [SRW-1:0] curSr,
  input  logic [AW-1:0]  sspIn,
  output logic           memReq,
  output logic           memWe,
  output logic           memSize,
  output logic [AW-1:0]  memAddr,
  output logic [AW-1:0]  memWdata,
  input  logic [AW-1:0]  memRdata,
  input  logic           memReady,
  input  logic           memBusErr,
  output logic           busy,
  output logic           done,
  output logic           halted,
  output logic           resetTaken,
  output logic [AW-1:0]  newPc,
  output logic [SRW-1:0] newSr,
  output logic [AW-1:0]  newSsp
);
  strobe_t       stb;
  logic          rstHit;
  logic [AW-1:0] srWide;

  trap_seq_ctrl #(.RST_HOLD(RST_HOLD)) ctrl_i (
    .clk(clk), .rstN(rstN), .extRstN(extRstN), .extHaltN(extHaltN),
    .startEntry(startEntry), .startReturn(startReturn),
    .memReady(memReady), .memBusErr(memBusErr), .stb(stb),
    .memReq(memReq), .busy(busy), .done(done), .halted(halted),
    .resetTaken(resetTaken), .rstHit(rstHit)
  );

  trap_seq_dpath #(.AW(AW), .SRW(SRW), .VW(VW), .S_BIT(S_BIT), .T_BIT(T_BIT)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .vecNum(vecNum), .curPc(curPc),
    .curSr(curSr), .sspIn(sspIn), .memRdata(memRdata), .memWe(memWe),
    .memSize(memSize), .memAddr(memAddr), .memWdata(memWdata),
    .newPc(newPc), .newSr(srWide), .newSsp(newSsp)
  );

  assign newSr = srWide[SRW-1:0];

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !memBusErr && !rstHit)
      |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memSize)));  // R7
endmodule

// File: tb/trap_seq_tb_top.sv
`timescale 1ns/1ps
module trap_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extRstN = 1'b1, extHaltN = 1'b1;
  logic        startEntry = 1'b0, startReturn = 1'b0;
  logic [7:0]  vecNum = '0;
  logic [31:0] curPc = '0, sspIn = '0;
  logic [15:0] curSr = '0;
  logic        memReq, memWe, memSize;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0, memBusErr = 1'b0;
  logic        busy, done, halted, resetTaken;
  logic [31:0] newPc, newSsp;
  logic [15:0] newSr;

  int checks = 0, failures = 0;
  int latency = 0, waitCnt = 0, errArm = 0;
  int logN = 0;
  logic [31:0] logAddr [8];
  logic [31:0] logData [8];
  logic        logWe [8];
  logic        logSize [8];

  always #10 clk = ~clk;  // 50 MHz

  trap_seq dut_i (
    .clk(clk), .rstN(rstN), .extRstN(extRstN), .extHaltN(extHaltN),
    .startEntry(startEntry), .startReturn(startReturn), .vecNum(vecNum),
    .curPc(curPc), .curSr(curSr), .sspIn(sspIn), .memReq(memReq),
    .memWe(memWe), .memSize(memSize), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .memBusErr(memBusErr),
    .busy(busy), .done(done), .halted(halted), .resetTaken(resetTaken),
    .newPc(newPc), .newSr(newSr), .newSsp(newSsp)
  );

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // memory model: answers after `latency` wait cycles, logs each granted access
  always @(negedge clk) begin
    memReady  = 1'b0;
    memBusErr = 1'b0;
    memRdata  = '0;
    if (memReq) begin
      if (waitCnt >= latency) begin
        waitCnt = 0;
        if (errArm != 0) begin
          memBusErr = 1'b1;
          errArm = 0;
        end else begin
          memReady = 1'b1;
          memRdata = memSize ? memFn(memAddr) : {16'h0, memFn(memAddr)[15:0]};
          if (logN < 8) begin
            logAddr[logN] = memAddr;
            logData[logN] = memWdata;
            logWe[logN]   = memWe;
            logSize[logN] = memSize;
            logN++;
          end
        end
      end else waitCnt++;
    end else waitCnt = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic holdReset(input int edges, input bit both);
    @(negedge clk);
    extRstN = 1'b0;
    extHaltN = both ? 1'b0 : 1'b1;
    repeat (edges) @(negedge clk);
  endtask

  task automatic releaseReset();
    extRstN = 1'b1;
    extHaltN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runEntry(input logic [7:0] v, input logic [31:0] pc, input logic [15:0] sr,
                          input logic [31:0] ssp, input int lat);
    int n;
    latency = lat;
    logN = 0;
    @(negedge clk);
    vecNum = v; curPc = pc; curSr = sr; sspIn = ssp; startEntry = 1'b1;
    @(negedge clk);
    startEntry = 1'b0;
    curSr = ~sr;  // later changes must not matter
    chk("R7 busy during entry", {31'b0, busy}, 32'd1);
    waitDone(n);
    chk("R7 entry cycles", n, 3 * (lat + 1));
    chk("R5 done", {31'b0, done}, 32'd1);
    chk("R5 busy low at done", {31'b0, busy}, 32'd0);
    chk("R3 access count", logN, 3);
    chk("R3 vector addr", logAddr[0], {22'b0, v, 2'b00});
    chk("R3 vector read 32", {30'b0, logWe[0], logSize[0]}, 32'd1);
    chk("R4 pc push addr", logAddr[1], ssp - 32'd4);
    chk("R4 pc push data", logData[1], pc);
    chk("R4 pc push write 32", {30'b0, logWe[1], logSize[1]}, 32'd3);
    chk("R4 sr push addr", logAddr[2], ssp - 32'd6);
    chk("R4 sr push write 16", {30'b0, logWe[2], logSize[2]}, 32'd2);
    chk("R1 pushed sr unmodified", {16'b0, logData[2][15:0]}, {16'b0, sr});
    chk("R2 new sr", {16'b0, newSr}, {16'b0, (sr | 16'h2000) & 16'h7FFF});
    chk("R5 new pc is handler", newPc, memFn({22'b0, v, 2'b00}));
    chk("R4 new ssp", newSsp, ssp - 32'd6);
    @(negedge clk);
    chk("R5 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic runReturn(input logic [31:0] ssp, input int lat);
    int n;
    latency = lat;
    logN = 0;
    @(negedge clk);
    sspIn = ssp; startReturn = 1'b1;
    @(negedge clk);
    startReturn = 1'b0;
    waitDone(n);
    chk("R7 return cycles", n, 2 * (lat + 1));
    chk("R6 access count", logN, 2);
    chk("R6 sr pop addr", logAddr[0], ssp);
    chk("R6 sr pop read 16", {30'b0, logWe[0], logSize[0]}, 32'd0);
    chk("R6 pc pop addr", logAddr[1], ssp + 32'd2);
    chk("R6 pc pop read 32", {30'b0, logWe[1], logSize[1]}, 32'd1);
    chk("R6 new sr", {16'b0, newSr}, {16'b0, memFn(ssp)[15:0]});
    chk("R6 new pc", newPc, memFn(ssp + 32'd2));
    chk("R6 new ssp", newSsp, ssp + 32'd6);
  endtask

  task automatic testBusyIgnore();
    int n;
    latency = 3;
    logN = 0;
    @(negedge clk);
    vecNum = 8'h21; curPc = 32'h0000_4000; curSr = 16'h0700; sspIn = 32'h0000_8000;
    startEntry = 1'b1; startReturn = 1'b1;  // R11 entry wins
    @(negedge clk);
    startEntry = 1'b0; startReturn = 1'b0;
    @(negedge clk);
    vecNum = 8'h33; sspIn = 32'h0000_9000; startEntry = 1'b1; startReturn = 1'b1;
    @(negedge clk);
    startEntry = 1'b0; startReturn = 1'b0;
    waitDone(n);
    chk("R11 one sequence only", logN, 3);
    chk("R11 entry chosen", {31'b0, logWe[1]}, 32'd1);
    chk("R11 first vector kept", newPc, memFn(32'h84));
    chk("R11 first ssp kept", newSsp, 32'h0000_7FFA);
  endtask

  task automatic testDoubleFault();
    latency = 1;
    errArm = 1;
    @(negedge clk);
    vecNum = 8'h02; curPc = 32'h100; curSr = 16'h0; sspIn = 32'h2000; startEntry = 1'b1;
    @(negedge clk);
    startEntry = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 halted after bus error", {31'b0, halted}, 32'd1);
    chk("R8 no request when halted", {30'b0, memReq, busy}, 32'd0);
    startReturn = 1'b1;
    @(negedge clk);
    startReturn = 1'b0;
    @(negedge clk);
    chk("R8 command ignored when halted", {30'b0, memReq, halted}, 32'd1);
  endtask

  task automatic testQualify();
    holdReset(9, 1'b1);
    chk("R9 nine clocks not taken", {31'b0, resetTaken}, 32'd0);
    releaseReset();
    chk("R9 still halted after short hold", {31'b0, halted}, 32'd1);
    holdReset(12, 1'b0);
    chk("R9 one pin only", {31'b0, resetTaken}, 32'd0);
    releaseReset();
    holdReset(5, 1'b1);
    extHaltN = 1'b1;
    @(negedge clk);
    extHaltN = 1'b0;
    repeat (9) @(negedge clk);
    chk("R9 broken hold restarts", {31'b0, resetTaken}, 32'd0);
    @(negedge clk);
    chk("R9 tenth clock taken", {31'b0, resetTaken}, 32'd1);
    chk("R10 halt cleared", {31'b0, halted}, 32'd0);
    releaseReset();
    chk("R9 taken drops on release", {31'b0, resetTaken}, 32'd0);
  endtask

  task automatic testAbort();
    latency = 5;
    @(negedge clk);
    vecNum = 8'h05; curPc = 32'h300; curSr = 16'h0; sspIn = 32'h4000; startEntry = 1'b1;
    @(negedge clk);
    startEntry = 1'b0;
    extRstN = 1'b0; extHaltN = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 aborted to idle", {29'b0, busy, memReq, halted}, 32'd0);
    chk("R10 reset taken", {31'b0, resetTaken}, 32'd1);
    releaseReset();
    repeat (3) @(negedge clk);
    chk("R10 stays idle", {30'b0, busy, done}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R5 reset state", {27'b0, busy, done, halted, resetTaken, memReq}, 32'd0);
    runEntry(8'h19, 32'h0000_1234, 16'h8004, 32'h0000_1000, 0);
    runEntry(8'hFF, 32'hDEAD_BEE0, 16'h271F, 32'h00FF_FF00, 2);
    runReturn(32'h0000_0FFA, 0);
    runReturn(32'h1234_567A, 4);
    testBusyIgnore();
    testDoubleFault();
    testQualify();
    testAbort();
    runEntry(8'h40, 32'h0000_0AA0, 16'h0000, 32'h0000_2000, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule